// File: doc/BRIEF.md
# Branch Sequencer with Condition Flag

This block drives the fetch address of a small pipelined CPU that uses 16-bit instructions. On each cycle that `in_valid` is high it takes one decoded instruction, which is the one at the current `fetch_pc`. The instruction arrives as a class code, two 32-bit register operands and a signed branch displacement. From these the block computes the address to fetch next. It also keeps a single condition flag, T. Only the two compare classes write T, and the two conditional branch classes test it.

An unconditional branch has one architectural delay slot. The instruction that sits after the branch always executes, and fetch moves to the branch target only after that instruction. Conditional branches have no delay slot. When one is taken, the fetch that would have followed it is discarded, and a one-cycle `squash` pulse reports this to the pipeline. A branch of any kind that sits in a delay slot is illegal. The block flags it and does not follow it.

Top module: `branch_seq`

## Requirements
- R1: While `rst` is high, and at the first sample after reset, `fetch_pc` equals `reset_vec`, and `t_flag`, `in_slot`, `slot_err` and `squash` are 0.
- R2: A valid instruction of a class other than the branch classes (3, 4 and 5) that is not in a delay slot advances `fetch_pc` by 2.
- R3: A valid class 3 instruction (unconditional branch) that is not in a delay slot sets `fetch_pc` to its own address plus 2 and raises `in_slot`. The next valid instruction then sets `fetch_pc` to the branch address + 4 + 2×sign-extended `disp` and clears `in_slot`.
- R4: Class 1 (compare equal) sets `t_flag` to 1 when `op_a` equals `op_b` and to 0 otherwise.
- R5: Class 2 (compare signed greater-or-equal) sets `t_flag` to 1 when `op_a` is greater than or equal to `op_b` as two's-complement values, and to 0 otherwise.
- R6: Every class other than 1 and 2 leaves `t_flag` unchanged. This covers class 0 (arithmetic) and the unused codes 6 and 7.
- R7: Class 4 (branch if T set), outside a delay slot: when `t_flag` is 1, `fetch_pc` becomes the branch address + 4 + 2×sign-extended `disp` and `squash` is 1 for one cycle. When `t_flag` is 0, `fetch_pc` advances by 2 and `squash` stays 0.
- R8: Class 5 (branch if T clear) behaves as R7 does, but it is taken when `t_flag` is 0.
- R9: A valid class 3, 4 or 5 instruction in a delay slot raises `slot_err` for one cycle and does not redirect fetch. `fetch_pc` goes to the pending delay-slot target, and `squash` stays 0.
- R10: A cycle with `in_valid` low leaves `fetch_pc`, `t_flag` and `in_slot` unchanged and clears `slot_err` and `squash`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | ADDR_W | Address that `fetch_pc` loads on reset |
| in_valid | input | 1 | A decoded instruction is present this cycle |
| in_class | input | 3 | Instruction class: 0 arith, 1 cmp-eq, 2 cmp-ge, 3 branch, 4 branch-if-T, 5 branch-if-not-T |
| op_a | input | DATA_W | First register operand |
| op_b | input | DATA_W | Second register operand |
| disp | input | DISP_W | Signed branch displacement, counted in instructions |
| fetch_pc | output | ADDR_W | Address of the next instruction to fetch |
| t_flag | output | 1 | Condition flag T |
| in_slot | output | 1 | The next instruction executes in a delay slot |
| slot_err | output | 1 | A branch was found in a delay slot |
| squash | output | 1 | A taken conditional branch discarded the fall-through fetch |

## Verification
Every output is registered, so each result is due at the first rising edge after the cycle that presents the instruction. This holds for the next fetch address, the new T value, the delay-slot marker, the error pulse and the squash pulse. The redirect of an unconditional branch is the one exception: it appears one valid instruction later, after the slot instruction's edge, and idle cycles between the two may stretch that delay. The bench drives inputs on the falling edge and at the same moment queues the values due at the following rising edge. A monitor then compares them 1 ns after that edge, so each check lands on exactly one edge.

// File: rtl/bs_pkg.sv
package bs_pkg;
  typedef enum logic [2:0] {
    CL_ARITH = 3'd0,
    CL_CMPEQ = 3'd1,
    CL_CMPGE = 3'd2,
    CL_BRA   = 3'd3,
    CL_BT    = 3'd4,
    CL_BF    = 3'd5
  } insn_class_e;
endpackage

// File: rtl/bs_flag.sv
module bs_flag #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [2:0]        cls,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              t_q
);
  import bs_pkg::*;

  logic is_cmp;
  logic cmp_res;

  always_comb begin
    is_cmp  = 1'b0;
    cmp_res = 1'b0;
    case (cls)
      CL_CMPEQ: begin is_cmp = 1'b1; cmp_res = (op_a == op_b); end
      CL_CMPGE: begin is_cmp = 1'b1; cmp_res = ($signed(op_a) >= $signed(op_b)); end
      default:  begin is_cmp = 1'b0; cmp_res = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)               t_q <= 1'b0;
    else if (en && is_cmp) t_q <= cmp_res;
  end
endmodule

// File: rtl/bs_target.sv
module bs_target #(
  parameter int ADDR_W     = 32,
  parameter int DISP_W     = 8,
  parameter int INSN_BYTES = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] tgt
);
  localparam int              SHIFT = $clog2(INSN_BYTES);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(2 * INSN_BYTES);

  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp} << SHIFT;
    tgt      = pc + BASE + disp_ext;
  end
endmodule

// File: rtl/bs_seq.sv
module bs_seq #(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reset_vec,
  input  logic              en,
  input  logic [2:0]        cls,
  input  logic              t_cur,
  input  logic [ADDR_W-1:0] tgt,
  output logic [ADDR_W-1:0] pc_q,
  output logic              slot_q,
  output logic              err_q,
  output logic              squash_q
);
  import bs_pkg::*;

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] pend_q;
  logic is_bra, is_cond, is_br, cond_take;

  always_comb begin
    is_bra    = (cls == CL_BRA);
    is_cond   = (cls == CL_BT) || (cls == CL_BF);
    is_br     = is_bra || is_cond;
    cond_take = ((cls == CL_BT) && t_cur) || ((cls == CL_BF) && !t_cur);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= reset_vec;
      pend_q   <= '0;
      slot_q   <= 1'b0;
      err_q    <= 1'b0;
      squash_q <= 1'b0;
    end else begin
      err_q    <= 1'b0;
      squash_q <= 1'b0;
      if (en) begin
        if (slot_q) begin
          pc_q   <= pend_q;
          slot_q <= 1'b0;
          err_q  <= is_br;
        end else if (is_bra) begin
          pc_q   <= pc_q + STEP;
          pend_q <= tgt;
          slot_q <= 1'b1;
        end else if (is_cond && cond_take) begin
          pc_q     <= tgt;
          squash_q <= 1'b1;
        end else begin
          pc_q <= pc_q + STEP;
        end
      end
    end
  end
endmodule

// File: rtl/branch_seq.sv
module branch_seq #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DISP_W     = 8,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reset_vec,
  input  logic              in_valid,
  input  logic [2:0]        in_class,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              t_flag,
  output logic              in_slot,
  output logic              slot_err,
  output logic              squash
);
  logic [ADDR_W-1:0] br_tgt;

  bs_flag #(.DATA_W(DATA_W)) u_flag (
    .clk(clk), .rst(rst), .en(in_valid), .cls(in_class),
    .op_a(op_a), .op_b(op_b), .t_q(t_flag)
  );

  bs_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .pc(fetch_pc), .disp(disp), .tgt(br_tgt)
  );

  bs_seq #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_seq (
    .clk(clk), .rst(rst), .reset_vec(reset_vec), .en(in_valid),
    .cls(in_class), .t_cur(t_flag), .tgt(br_tgt),
    .pc_q(fetch_pc), .slot_q(in_slot), .err_q(slot_err), .squash_q(squash)
  );
endmodule

// File: rtl/bs_chk.sv
module bs_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_class,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              t_flag,
  input logic              in_slot,
  input logic              slot_err,
  input logic              squash
);
  // R6
  t_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class != 3'd1 && in_class != 3'd2) |=> $stable(t_flag));

  // R4
  cmp_eq_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 3'd1) |=> (t_flag == ($past(op_a) == $past(op_b))));

  // R3
  slot_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 3'd3 && !in_slot) |=> (in_slot && fetch_pc == $past(fetch_pc) + ADDR_W'(2)));

  // R9
  slot_err_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_slot && (in_class == 3'd3 || in_class == 3'd4 || in_class == 3'd5)) |=> (slot_err && !squash));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(fetch_pc) && $stable(in_slot) && !slot_err && !squash));

  // R7
  squash_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({squash, in_slot, slot_err}));
endmodule

bind branch_seq bs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
  .op_a(op_a), .op_b(op_b), .fetch_pc(fetch_pc), .t_flag(t_flag),
  .in_slot(in_slot), .slot_err(slot_err), .squash(squash)
);

// File: tb/branch_seq_bench.sv
module branch_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] reset_vec = 32'h0000_1000;
  logic        in_valid = 1'b0;
  logic [2:0]  in_class = 3'd0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [7:0]  disp = '0;
  logic [31:0] fetch_pc;
  logic        t_flag, in_slot, slot_err, squash;

  always #5 clk = ~clk;

  branch_seq u_branch_seq (
    .clk(clk), .rst(rst), .reset_vec(reset_vec), .in_valid(in_valid),
    .in_class(in_class), .op_a(op_a), .op_b(op_b), .disp(disp),
    .fetch_pc(fetch_pc), .t_flag(t_flag), .in_slot(in_slot),
    .slot_err(slot_err), .squash(squash)
  );

  typedef struct {
    logic [31:0] pc;
    logic t, slot, err, sq;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;

  logic [31:0] m_pc, m_pend;
  logic        m_t, m_slot;

  task automatic check_now(input exp_t e);
    checks++;
    if (fetch_pc !== e.pc || t_flag !== e.t || in_slot !== e.slot ||
        slot_err !== e.err || squash !== e.sq) begin
      errors++;
      $display("FAIL %s: pc/t/slot/err/sq actual %h/%b/%b/%b/%b expected %h/%b/%b/%b/%b",
               e.tag, fetch_pc, t_flag, in_slot, slot_err, squash,
               e.pc, e.t, e.slot, e.err, e.sq);
    end
  endtask

  // monitor: pops one expected item per rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check_now(exp_q.pop_front());
  end

  // driver: called at a falling edge; queues the state due after the next rising edge
  task automatic step(input bit v, input logic [2:0] c, input logic [31:0] a,
                      input logic [31:0] b, input logic [7:0] d, input string tag);
    exp_t e;
    logic [31:0] tgt;
    tgt = m_pc + 32'd4 + ({{24{d[7]}}, d} << 1);
    e.err = 1'b0;
    e.sq  = 1'b0;
    e.tag = tag;
    if (v) begin
      if (c == 3'd1) e.t = (a == b);
      else if (c == 3'd2) e.t = ($signed(a) >= $signed(b));
      else e.t = m_t;
      if (m_slot) begin
        e.pc = m_pend; e.slot = 1'b0;
        e.err = (c == 3'd3 || c == 3'd4 || c == 3'd5);
      end else if (c == 3'd3) begin
        e.pc = m_pc + 32'd2; e.slot = 1'b1; m_pend = tgt;
      end else if ((c == 3'd4 && m_t) || (c == 3'd5 && !m_t)) begin
        e.pc = tgt; e.slot = 1'b0; e.sq = 1'b1;
      end else begin
        e.pc = m_pc + 32'd2; e.slot = 1'b0;
      end
    end else begin
      e.pc = m_pc; e.t = m_t; e.slot = m_slot;
    end
    m_pc = e.pc; m_t = e.t; m_slot = e.slot;
    in_valid = v; in_class = c; op_a = a; op_b = b; disp = d;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.pc = 32'h1000; r.t = 0; r.slot = 0; r.err = 0; r.sq = 0; r.tag = "R1 in reset";
    check_now(r);
    rst = 1'b0;
    m_pc = 32'h1000; m_t = 0; m_slot = 0; m_pend = '0;
    @(posedge clk); #1;
    r.tag = "R1 after reset";
    check_now(r);
    @(negedge clk);

    step(1, 3'd0, 32'd1, 32'd2, 8'd0, "R2 arith");
    step(1, 3'd1, 32'd7, 32'd7, 8'd0, "R4 equal");
    step(1, 3'd0, 32'hFFFF_FFFF, 32'd1, 8'd0, "R6 add negative");
    step(1, 3'd6, 32'd3, 32'd9, 8'd0, "R6 code6");
    step(1, 3'd7, 32'd3, 32'd3, 8'd0, "R6 code7");
    step(1, 3'd1, 32'd7, 32'd8, 8'd0, "R4 unequal");
    step(1, 3'd2, 32'hFFFF_FFFF, 32'd1, 8'd0, "R5 -1 ge 1");
    step(1, 3'd2, 32'd5, 32'hFFFF_FFFD, 8'd0, "R5 5 ge -3");
    step(1, 3'd2, 32'h8000_0000, 32'h8000_0000, 8'd0, "R5 equal min");
    step(1, 3'd4, 32'd0, 32'd0, 8'd6, "R7 BT taken");
    step(0, 3'd3, 32'd0, 32'd0, 8'd0, "R10 idle");
    step(1, 3'd5, 32'd0, 32'd0, 8'd6, "R8 BF not taken");
    step(1, 3'd2, 32'd1, 32'd2, 8'd0, "R5 1 ge 2");
    step(1, 3'd4, 32'd0, 32'd0, 8'd3, "R7 BT not taken");
    step(1, 3'd5, 32'd0, 32'd0, 8'h80, "R8 BF taken min disp");
    step(1, 3'd3, 32'd0, 32'd0, 8'h10, "R3 branch");
    step(0, 3'd0, 32'd0, 32'd0, 8'd0, "R10 idle in slot");
    step(1, 3'd1, 32'd4, 32'd4, 8'd0, "R3 slot cmp redirect");
    step(1, 3'd3, 32'd0, 32'd0, 8'hFE, "R3 branch back");
    step(1, 3'd3, 32'd0, 32'd0, 8'd20, "R9 bra in slot");
    step(1, 3'd0, 32'd0, 32'd0, 8'd0, "R2 after err");
    step(1, 3'd3, 32'd0, 32'd0, 8'd2, "R3 branch");
    step(1, 3'd4, 32'd0, 32'd0, 8'd30, "R9 BT in slot");
    step(0, 3'd0, 32'd0, 32'd0, 8'd0, "R10 idle clears");
    step(1, 3'd0, 32'd0, 32'd0, 8'd0, "R2 arith");
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule